// File: doc/BRIEF.md
# Phase-shifted full-bridge PWM generator

This block produces the four gate-drive signals of a full bridge from a free-running period counter. Each bridge leg is driven by one complementary pair of outputs. Both pairs run at a nominal 50% duty and at the same frequency. Power is controlled by shifting the timing of one leg against the other, not by changing pulse width. The A/B pair is aligned to the start of each cycle. The C/D pair carries the same waveform delayed by a shift that is derived from a digital phase command.

Each leg has its own programmable turn-on dead-time. An output only rises after its partner has been low for the programmed number of clocks, and turn-off is never delayed. A force-off input blanks all four outputs at once. When force-off is released, switching restarts cleanly from a cycle start. New settings are taken only at a cycle boundary, so a cycle already running always finishes with the settings it started with.

Top module: `psfb_pwm`

## Requirements
- R1: While `rst_n` is low, all four outputs are low. After reset, no output switches until the block has passed through a cycle start.
- R2: A cycle lasts 2H clocks, counted 0 to 2H-1. The A/B leg demands A on counts 0..H-1 and B on counts H..2H-1. Each output follows its demand one clock later. With a dead-time D, A is therefore high on counts D+1..H, and B is high on counts H+D+1..2H-1 plus count 0 of the next cycle. Each output is high for H-D clocks per cycle.
- R3: The two outputs of one leg (A and B, or C and D) are never high in the same cycle.
- R4: The shift is S = floor(min(phase,2^PH_W)·H / 2^PH_W) clocks, and the C/D demand equals the A/B demand delayed by S clocks. Any phase of 2^PH_W (256 by default) or more gives S = H, which is 180 degrees: C then matches B and D matches A on every cycle.
- R5: A phase below ZERO_TH (16 by default) forces S = 0, so C matches A when both legs have the same dead-time. A phase equal to ZERO_TH is not forced.
- R6: An output turns on only after its leg's demand has held that side for D clocks. It turns off one clock after its demand leaves it, with no further delay. Both outputs of a leg are therefore low for exactly D clocks at each changeover.
- R7: The A/B leg uses dead-time D_ab and the C/D leg uses D_cd. Each is set by its own input.
- R8: A programmed dead-time below MIN_DT (2 by default) is raised to MIN_DT. A programmed dead-time above H-1 is lowered to H-1.
- R9: While force-off is high, all four outputs are low in that same cycle. When force-off is sampled low at a clock edge, the next cycle is count 0. All outputs stay low in that cycle, and each leg's first turn-on gets the full dead-time.
- R10: Half-period, phase and both dead-times are sampled only at the last count of a cycle, or while the block is reset or forced off. Changing them in the middle of a cycle has no effect until the next cycle starts.
- R11: A half-period input below MIN_HALF (4 by default) is raised to MIN_HALF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| half_per_i | input | CNT_W | Half-period H in clocks |
| phase_i | input | PH_W+1 | Phase command, where 2^PH_W means 180 degrees |
| dead_ab_i | input | CNT_W | Turn-on dead-time of the A/B leg, in clocks |
| dead_cd_i | input | CNT_W | Turn-on dead-time of the C/D leg, in clocks |
| force_off_i | input | 1 | Holds all outputs low and restarts the cycle on release |
| gate_a_o | output | 1 | Leg 1 drive, high in the first half of the cycle |
| gate_b_o | output | 1 | Leg 1 complementary drive |
| gate_c_o | output | 1 | Leg 2 drive, shifted by S |
| gate_d_o | output | 1 | Leg 2 complementary drive |

## Verification
The bench targets the following corner cases and the failure each one would reveal:
- Phase commands at zero, just under and exactly at the zero threshold, at full scale and above full scale. A design with a wrong saturation or a wrong comparison would leave C offset from A by one clock, or fail to line C up with B.
- Dead-times of zero and of more than half the period. These expose a missing clamp, which would show as a both-low gap that is too short or two outputs high at once.
- A settings change in the middle of a cycle. This would catch a design that loads settings immediately and so cuts the current cycle short.
- Release of force-off. This would catch an output that rises in the first cycle, or before its full dead-time has passed.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  typedef enum logic {
    TB_IDLE = 1'b0,
    TB_RUN  = 1'b1
  } tb_state_e;

  localparam int NUM_LEGS = 2;
  localparam int LEG_AB   = 0;
  localparam int LEG_CD   = 1;

endpackage

// File: rtl/psfb_rst_sync.sv
module psfb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/psfb_timebase.sv
module psfb_timebase
  import psfb_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int PH_W     = 8,
  parameter int MIN_HALF = 4,
  parameter int MIN_DT   = 2,
  parameter int ZERO_TH  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CNT_W-1:0]                  half_i,
  input  logic [PH_W:0]                     phase_i,
  input  logic [CNT_W-1:0]                  dead_ab_i,
  input  logic [CNT_W-1:0]                  dead_cd_i,
  input  logic                              force_i,
  output logic                              run_o,
  output logic [CNT_W:0]                    cnt_o,
  output logic [CNT_W-1:0]                  half_o,
  output logic [CNT_W-1:0]                  shift_o,
  output logic [NUM_LEGS-1:0][CNT_W-1:0]    dead_o
);

  localparam int PER_W  = CNT_W + 1;
  localparam int PROD_W = PH_W + 1 + CNT_W;
  localparam logic [PH_W:0]    FULL_PH  = {1'b1, {PH_W{1'b0}}};
  localparam logic [PH_W:0]    ZERO_PH  = (PH_W+1)'(ZERO_TH);
  localparam logic [CNT_W-1:0] MIN_H_V  = CNT_W'(MIN_HALF);
  localparam logic [CNT_W-1:0] MIN_D_V  = CNT_W'(MIN_DT);

  tb_state_e                          state_q, state_d;
  logic [PER_W-1:0]                   cnt_q, cnt_d, last_cnt;
  logic [CNT_W-1:0]                   half_q, shift_q;
  logic [CNT_W-1:0]                   half_new, shift_new, half_m1;
  logic [NUM_LEGS-1:0][CNT_W-1:0]     dead_q, dead_new, dead_raw;
  logic [PH_W:0]                      ph_sat;
  logic [PROD_W-1:0]                  prod;
  logic                               wrap, load_en;

  // candidate settings, clamped
  always_comb begin
    half_new = (half_i < MIN_H_V) ? MIN_H_V : half_i;
    half_m1  = half_new - 1'b1;
    ph_sat   = (phase_i > FULL_PH) ? FULL_PH : phase_i;
    prod     = PROD_W'(ph_sat) * PROD_W'(half_new);
    shift_new = (phase_i < ZERO_PH) ? '0 : prod[PH_W +: CNT_W];
    dead_raw[LEG_AB] = dead_ab_i;
    dead_raw[LEG_CD] = dead_cd_i;
    for (int i = 0; i < NUM_LEGS; i++) begin
      dead_new[i] = (dead_raw[i] < MIN_D_V) ? MIN_D_V : dead_raw[i];
      if (dead_new[i] > half_m1) begin
        dead_new[i] = half_m1;
      end
    end
  end

  // counter and state next-state
  always_comb begin
    last_cnt = {half_q, 1'b0} - 1'b1;
    wrap     = (state_q == TB_RUN) && (cnt_q == last_cnt);
    load_en  = (state_q == TB_IDLE) || wrap;
    state_d  = force_i ? TB_IDLE : TB_RUN;
    cnt_d    = (force_i || load_en) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TB_IDLE;
      cnt_q   <= '0;
      half_q  <= MIN_H_V;
      shift_q <= '0;
      dead_q  <= {NUM_LEGS{MIN_D_V}};
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (load_en) begin
        half_q  <= half_new;
        shift_q <= shift_new;
        dead_q  <= dead_new;
      end
    end
  end

  assign run_o   = (state_q == TB_RUN);
  assign cnt_o   = cnt_q;
  assign half_o  = half_q;
  assign shift_o = shift_q;
  assign dead_o  = dead_q;

endmodule

// File: rtl/psfb_demand.sv
module psfb_demand
  import psfb_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W:0]        cnt_i,
  input  logic [CNT_W-1:0]      half_i,
  input  logic [CNT_W-1:0]      shift_i,
  output logic [NUM_LEGS-1:0]   dem_o
);

  logic [CNT_W:0] period, half_x, shift_x, pos_cd;

  always_comb begin
    period  = {half_i, 1'b0};
    half_x  = {1'b0, half_i};
    shift_x = {1'b0, shift_i};
    pos_cd  = (cnt_i >= shift_x) ? (cnt_i - shift_x) : (cnt_i + period - shift_x);
    dem_o[LEG_AB] = (cnt_i  < half_x);
    dem_o[LEG_CD] = (pos_cd < half_x);
  end

endmodule

// File: rtl/psfb_leg.sv
module psfb_leg #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             dem_i,
  input  logic [CNT_W-1:0] dead_i,
  output logic             hi_o,
  output logic             lo_o
);

  localparam logic [CNT_W-1:0] AGE_MAX = '1;

  logic             armed_q, armed_d;
  logic             cur_q, cur_d;
  logic [CNT_W-1:0] age_q, age_d;
  logic             open_q;

  always_comb begin
    armed_d = armed_q;
    cur_d   = cur_q;
    age_d   = age_q;
    if (!run_i) begin
      armed_d = 1'b0;
      age_d   = '0;
    end else begin
      armed_d = 1'b1;
      if (!armed_q || (dem_i != cur_q)) begin
        cur_d = dem_i;
        age_d = '0;
      end else if (age_q != AGE_MAX) begin
        age_d = age_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cur_q   <= 1'b0;
      age_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cur_q   <= cur_d;
      age_q   <= age_d;
    end
  end

  assign open_q = armed_q & run_i & (age_q >= dead_i);
  assign hi_o   = open_q &  cur_q;
  assign lo_o   = open_q & ~cur_q;

endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm
  import psfb_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int PH_W     = 8,
  parameter int MIN_HALF = 4,
  parameter int MIN_DT   = 2,
  parameter int ZERO_TH  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_per_i,
  input  logic [PH_W:0]    phase_i,
  input  logic [CNT_W-1:0] dead_ab_i,
  input  logic [CNT_W-1:0] dead_cd_i,
  input  logic             force_off_i,
  output logic             gate_a_o,
  output logic             gate_b_o,
  output logic             gate_c_o,
  output logic             gate_d_o
);

  logic                           rst_core_n;
  logic                           run;
  logic [CNT_W:0]                 cnt;
  logic [CNT_W-1:0]               half_q, shift_q;
  logic [NUM_LEGS-1:0][CNT_W-1:0] dead_q;
  logic [NUM_LEGS-1:0]            dem, hi, lo;

  psfb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  psfb_timebase #(
    .CNT_W(CNT_W), .PH_W(PH_W), .MIN_HALF(MIN_HALF),
    .MIN_DT(MIN_DT), .ZERO_TH(ZERO_TH)
  ) u_tb (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .half_i    (half_per_i),
    .phase_i   (phase_i),
    .dead_ab_i (dead_ab_i),
    .dead_cd_i (dead_cd_i),
    .force_i   (force_off_i),
    .run_o     (run),
    .cnt_o     (cnt),
    .half_o    (half_q),
    .shift_o   (shift_q),
    .dead_o    (dead_q)
  );

  psfb_demand #(.CNT_W(CNT_W)) u_dem (
    .cnt_i   (cnt),
    .half_i  (half_q),
    .shift_i (shift_q),
    .dem_o   (dem)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_leg #(.CNT_W(CNT_W)) u_leg (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .run_i  (run),
      .dem_i  (dem[g]),
      .dead_i (dead_q[g]),
      .hi_o   (hi[g]),
      .lo_o   (lo[g])
    );
  end

  assign gate_a_o = hi[LEG_AB] & ~force_off_i;
  assign gate_b_o = lo[LEG_AB] & ~force_off_i;
  assign gate_c_o = hi[LEG_CD] & ~force_off_i;
  assign gate_d_o = lo[LEG_CD] & ~force_off_i;

endmodule

// File: rtl/psfb_pwm_chk.sv
module psfb_pwm_chk (
  input logic clk,
  input logic rst_n,
  input logic force_off_i,
  input logic gate_a_o,
  input logic gate_b_o,
  input logic gate_c_o,
  input logic gate_d_o
);

  // R1: outputs low while reset is held
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> !(gate_a_o || gate_b_o || gate_c_o || gate_d_o));

  // R3: no leg conducts on both sides
  assert_pair_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a_o && gate_b_o) && !(gate_c_o && gate_d_o));

  // R9: force-off blanks every output in the same cycle
  assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |-> !(gate_a_o || gate_b_o || gate_c_o || gate_d_o));

  // R6/R8: each turn-on follows at least the minimum gap on the partner
  assert_gap_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_b_o) |-> (!$past(gate_a_o, 1) && !$past(gate_a_o, 2)));
  assert_gap_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_a_o) |-> (!$past(gate_b_o, 1) && !$past(gate_b_o, 2)));
  assert_gap_d_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_d_o) |-> (!$past(gate_c_o, 1) && !$past(gate_c_o, 2)));
  assert_gap_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_c_o) |-> (!$past(gate_d_o, 1) && !$past(gate_d_o, 2)));

endmodule

bind psfb_pwm psfb_pwm_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .force_off_i (force_off_i),
  .gate_a_o    (gate_a_o),
  .gate_b_o    (gate_b_o),
  .gate_c_o    (gate_c_o),
  .gate_d_o    (gate_d_o)
);

// File: tb/psfb_pwm_bench.sv
`timescale 1ns/1ps
module psfb_pwm_bench;

  localparam int CNT_W = 10;
  localparam int PH_W  = 8;
  localparam int MINH  = 4;
  localparam int MIND  = 2;
  localparam int ZTH   = 16;
  localparam int FULL  = 256;

  localparam int NV = 8;
  localparam int VH [NV] = '{8, 10, 6, 12, 16, 9, 2, 8};
  localparam int VP [NV] = '{128, 0, 256, 64, 200, 100, 128, 10};
  localparam int VA [NV] = '{3, 2, 2, 4, 0, 3, 1, 3};
  localparam int VC [NV] = '{2, 5, 2, 7, 40, 3, 1, 3};

  logic clk, rst_n, force_r;
  logic [CNT_W-1:0] half_r, dab_r, dcd_r;
  logic [PH_W:0] phase_r;
  logic ga, gb, gc, gd;
  int nchk, nerr;
  bit done;

  psfb_pwm #(.CNT_W(CNT_W), .PH_W(PH_W), .MIN_HALF(MINH), .MIN_DT(MIND), .ZERO_TH(ZTH))
  u_psfb_pwm (
    .clk(clk), .rst_n(rst_n), .half_per_i(half_r), .phase_i(phase_r),
    .dead_ab_i(dab_r), .dead_cd_i(dcd_r), .force_off_i(force_r),
    .gate_a_o(ga), .gate_b_o(gb), .gate_c_o(gc), .gate_d_o(gd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_half(input int h);
    return (h < MINH) ? MINH : h;
  endfunction
  function automatic int f_shift(input int ph, input int h);
    int p;
    p = (ph > FULL) ? FULL : ph;
    if (ph < ZTH) return 0;
    return (p * h) / FULL;
  endfunction
  function automatic int f_dead(input int d, input int h);
    int e;
    e = (d < MIND) ? MIND : d;
    if (e > h - 1) e = h - 1;
    return e;
  endfunction

  // Restart through force-off, then run against a cycle model of R2/R4/R6/R9/R10
  task automatic run_cfg(input int h, ph, da, dc, nper, chg_k, h2, ph2, da2, dc2,
                         output int mism, output int fk, output int fact, output int fexp,
                         output int lowab, output int lowcd, output int hia,
                         output bit ca_eq, output bit cb_eq);
    int H, P, P0, S, DA, DC, mc, aab, acd;
    bit arm, cab, ccd, rab, rcd, ea, eb, ec, ed;
    mism = 0; fk = -1; fact = 0; fexp = 0; lowab = 0; lowcd = 0; hia = 0;
    ca_eq = 1; cb_eq = 1;
    @(negedge clk);
    force_r = 1'b1;
    half_r = CNT_W'(h); phase_r = (PH_W+1)'(ph); dab_r = CNT_W'(da); dcd_r = CNT_W'(dc);
    @(negedge clk);
    @(negedge clk);
    force_r = 1'b0;
    H = f_half(h); P = 2 * H; P0 = P; S = f_shift(ph, H);
    DA = f_dead(da, H); DC = f_dead(dc, H);
    mc = 0; aab = 0; acd = 0; arm = 0; cab = 0; ccd = 0;
    for (int k = 0; k < nper * P0; k++) begin
      @(negedge clk);
      if (k == chg_k) begin
        half_r = CNT_W'(h2); phase_r = (PH_W+1)'(ph2);
        dab_r = CNT_W'(da2); dcd_r = CNT_W'(dc2);
      end
      ea = arm &&  cab && (aab >= DA);
      eb = arm && !cab && (aab >= DA);
      ec = arm &&  ccd && (acd >= DC);
      ed = arm && !ccd && (acd >= DC);
      if ({ga, gb, gc, gd} != {ea, eb, ec, ed}) begin
        if (mism == 0) begin
          fk = k; fact = int'({ga, gb, gc, gd}); fexp = int'({ea, eb, ec, ed});
        end
        mism++;
      end
      if (k >= P0 && k < 2 * P0) begin
        if (!ga && !gb) lowab++;
        if (!gc && !gd) lowcd++;
        if (ga) hia++;
      end
      if (gc != ga) ca_eq = 0;
      if (gc != gb || gd != ga) cb_eq = 0;
      rab = (mc < H);
      rcd = (((mc + P - S) % P) < H);
      if (!arm || rab != cab) begin cab = rab; aab = 0; end else aab++;
      if (!arm || rcd != ccd) begin ccd = rcd; acd = 0; end else acd++;
      arm = 1;
      if (mc == P - 1) begin
        mc = 0;
        H = f_half(int'(half_r)); P = 2 * H; S = f_shift(int'(phase_r), H);
        DA = f_dead(int'(dab_r), H); DC = f_dead(int'(dcd_r), H);
      end else begin
        mc++;
      end
    end
  endtask

  initial begin
    int mism, fk, fact, fexp, lowab, lowcd, hia;
    bit ca_eq, cb_eq;
    int H, DA, DC, n;
    nchk = 0; nerr = 0; done = 0;
    rst_n = 1'b0; force_r = 1'b0;
    half_r = 10'd8; phase_r = 9'd128; dab_r = 10'd3; dcd_r = 10'd3;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({ga, gb, gc, gd} == 4'b0, "R1 outputs during reset", int'({ga, gb, gc, gd}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R2 R4 R6 R7 R8 R9 waveform and per-cycle statistics
    for (int v = 0; v < NV; v++) begin
      run_cfg(VH[v], VP[v], VA[v], VC[v], 3, -1, 0, 0, 0, 0,
              mism, fk, fact, fexp, lowab, lowcd, hia, ca_eq, cb_eq);
      H = f_half(VH[v]); DA = f_dead(VA[v], H); DC = f_dead(VC[v], H);
      check(mism == 0, $sformatf("R2 R4 R9 vector %0d waveform at cycle %0d", v, fk), fact, fexp);
      check(lowab == 2 * DA, $sformatf("R6 R8 vector %0d A/B both-low clocks", v), lowab, 2 * DA);
      check(lowcd == 2 * DC, $sformatf("R7 R8 vector %0d C/D both-low clocks", v), lowcd, 2 * DC);
      check(hia == H - DA, $sformatf("R2 vector %0d A high clocks", v), hia, H - DA);
    end

    // R5: below the zero threshold C follows A; at the threshold it does not
    run_cfg(20, 15, 3, 3, 2, -1, 0, 0, 0, 0, mism, fk, fact, fexp, lowab, lowcd, hia, ca_eq, cb_eq);
    check(ca_eq == 1, "R5 phase below threshold gives zero shift", int'(ca_eq), 1);
    run_cfg(20, 16, 3, 3, 2, -1, 0, 0, 0, 0, mism, fk, fact, fexp, lowab, lowcd, hia, ca_eq, cb_eq);
    check(ca_eq == 0, "R5 phase at threshold not forced", int'(ca_eq), 0);
    check(mism == 0, "R4 phase at threshold waveform", fact, fexp);

    // R4: above full scale saturates to 180 degrees
    run_cfg(10, 300, 3, 3, 2, -1, 0, 0, 0, 0, mism, fk, fact, fexp, lowab, lowcd, hia, ca_eq, cb_eq);
    check(cb_eq == 1, "R4 saturated phase C=B D=A", int'(cb_eq), 1);

    // R11: short half-period raised to the minimum
    run_cfg(1, 0, 2, 2, 2, -1, 0, 0, 0, 0, mism, fk, fact, fexp, lowab, lowcd, hia, ca_eq, cb_eq);
    check(hia == MINH - MIND, "R11 minimum half-period A high clocks", hia, MINH - MIND);
    check(mism == 0, "R11 minimum half-period waveform", fact, fexp);

    // R10: settings changed mid-cycle take effect only at the next cycle start
    run_cfg(8, 128, 3, 3, 4, 5, 6, 256, 2, 4, mism, fk, fact, fexp, lowab, lowcd, hia, ca_eq, cb_eq);
    check(mism == 0, $sformatf("R10 mid-cycle change at cycle %0d", fk), fact, fexp);

    // R9: force-off blanks outputs immediately
    n = 0;
    @(negedge clk);
    while (!(ga || gb) && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(ga || gb, "R9 leg active before force", int'({ga, gb}), 1);
    force_r = 1'b1;
    #1;
    check({ga, gb, gc, gd} == 4'b0, "R9 outputs low under force", int'({ga, gb, gc, gd}), 0);
    repeat (3) @(negedge clk);
    check({ga, gb, gc, gd} == 4'b0, "R9 outputs held low under force", int'({ga, gb, gc, gd}), 0);
    force_r = 1'b0;
    @(negedge clk);
    check({ga, gb, gc, gd} == 4'b0, "R9 first cycle after release low", int'({ga, gb, gc, gd}), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule